// File: doc/BRIEF.md
# Channel I/O Register with Byte Packing

This block holds one 16-bit I/O register that serves both directions of a small channel-addressed I/O path, and executes the register-transfer operations that move words or bytes between a caller's accumulator and that register. A request carries a decoded operation code, a 5-bit channel number, a hold/clear-flag bit, the current accumulator value and the external input bus. The block answers with the updated accumulator and a skip indication. It drives the register contents onto the output bus and provides an active-low control-enable strobe.

Channel 1 moves whole words and owns a held control-enable level, which the skip tests read. Channel 0 is the byte-packing channel. Each of its transfers touches only the low byte of the register, turns the accumulator's bytes around so that the next byte is ready, and pulses the strobe low for one clock. The four select-code bits at the top of the register are never overwritten from the input bus. Input data reaches the accumulator only through the register: a capture operation loads the register first, and a later load or merge reads it.

Requests use a valid/ready handshake, and so do the results. A request is accepted on a rising edge where `op_valid` and `op_ready` are both high. Its result is presented from the next cycle with `res_valid` high, and it stays unchanged until a cycle in which `res_ready` is high. `op_ready` equals `!res_valid || res_ready`, so there is at most one result in flight and a new request can be accepted in the same cycle the previous result is taken. Register, output bus and strobe effects take place at the accepting edge, whatever the state of `res_ready`.

Top module: `chan_ioreg`

## Requirements
- R1: Channel 1, op_code 0 (output): the register takes the whole accumulator word. `out_bus` shows it from the cycle after acceptance, and the returned accumulator is unchanged.
- R2: Channel 1, op_code 1 (load) returns the register value held at acceptance. Op_code 2 (merge) returns the accumulator OR that register value.
- R3: Channel 0, op_code 0: register bits 7..0 take accumulator bits 7..0 and register bits 15..8 are kept. The returned accumulator is the input with its two bytes swapped.
- R4: Channel 0, op_code 1: the returned accumulator has register bits 7..0 in bits 15..8, and its own bits 7..0 are kept.
- R5: Channel 0, op_code 2: register bits 7..0 are ORed into accumulator bits 7..0 first, and the two bytes of the result are then swapped.
- R6: Each accepted channel-0 transfer (op_code 0, 1 or 2) drives `ceo_n` low during the cycle after acceptance only. Without a further channel-0 transfer, and with the channel-1 level high, `ceo_n` is high again in the cycle after that.
- R7: Channel 1, op_code 3 (set control) holds `ceo_n` low, and op_code 6 (clear flag) returns it high. Op_code 7 skips when this held level is low, op_code 8 skips when it is high, and every other operation returns skip 0.
- R8: Channel 1, op_code 5 (capture) loads register bits 11..0 from `in_bus` bits 11..0. Register bits 15..12 are kept.
- R9: `op_ready` is `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, `res_acc` and `res_skip` hold still. `res_valid` falls after a result is taken if no request is accepted in that cycle.
- R10: After reset the register is zero, `ceo_n` is high and `res_valid` is low.
- R11: Requests on channels 2 to 31 return the accumulator unchanged with skip 0, and leave the register and `ceo_n` unchanged. So do the following requests: on channel 0, op_codes 3 to 8; on channel 1, op_code 4. The hold/clear-flag bit has no effect on any request.
- R12: Op_codes 9 to 15 act like R11 on every channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Request can be accepted this cycle |
| op_code | input | 4 | 0 output, 1 load, 2 merge, 3 set control, 4 clear control, 5 capture, 6 clear flag, 7 skip if level low, 8 skip if level high |
| op_chan | input | 5 | Channel number |
| op_hold_clr | input | 1 | Hold/clear-flag bit, has no effect |
| op_acc | input | 16 | Accumulator value |
| in_bus | input | 16 | External input bus |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken this cycle |
| res_acc | output | 16 | Updated accumulator |
| res_skip | output | 1 | Skip indication |
| out_bus | output | 16 | Register contents |
| ceo_n | output | 1 | Active-low control-enable strobe |

## Verification
Directed sequences use byte values that differ in each half, such as 0x1234 and 0xA5C3. With these values, the byte swaps of R3 and R5 and the byte placement of R4 produce results that a straight copy cannot mimic. Some merge and load operations deliberately read a register value left by an earlier operation. This separates "register as held at acceptance" from "register as just written", and a capture with an all-ones input bus shows whether the top four bits are protected. A random phase mixes all sixteen op codes over channels 0, 1 and out-of-range channels, with `res_ready` toggled at random. It exercises back-pressure, ignored requests and back-to-back channel-0 strobes against a reference model on every clock.

// File: rtl/chan_ioreg_pkg.sv
package chan_ioreg_pkg;
  localparam int DATA_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 4;
  localparam int CHAN_W   = 5;
  localparam int OPCODE_W = 4;

  typedef enum logic [OPCODE_W-1:0] {
    OPC_OUT  = 4'd0,
    OPC_LOAD = 4'd1,
    OPC_MRG  = 4'd2,
    OPC_SETC = 4'd3,
    OPC_CLRC = 4'd4,
    OPC_CAPT = 4'd5,
    OPC_CLRF = 4'd6,
    OPC_SKLO = 4'd7,
    OPC_SKHI = 4'd8
  } opc_e;
endpackage

// File: rtl/chan_ioreg_decode.sv
module chan_ioreg_decode
  import chan_ioreg_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int BW  = BYTE_W,
  parameter int SW  = SEL_W,
  parameter int CW  = CHAN_W,
  parameter int OCW = OPCODE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OCW-1:0] op_code,
  input  logic [CW-1:0]  op_chan,
  input  logic           op_hold_clr,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  in_bus,
  input  logic [DW-1:0]  ior,
  input  logic           lvl_n,
  output logic [DW-1:0]  acc_nxt,
  output logic           skip,
  output logic           ior_we,
  output logic [DW-1:0]  ior_nxt,
  output logic           lvl_set,
  output logic           lvl_clr,
  output logic           strobe
);
  localparam int CAPW = DW - SW;
  localparam int HIW  = DW - BW;

  logic is_ch0, is_ch1;
  logic [DW-1:0] low_byte;
  logic [DW-1:0] merged0;
  logic unused_bits;

  assign is_ch0 = (op_chan == CW'(0));
  assign is_ch1 = (op_chan == CW'(1));
  assign low_byte = {{HIW{1'b0}}, ior[BW-1:0]};
  assign merged0  = acc | low_byte;
  assign unused_bits = ^{op_hold_clr, in_bus[DW-1:CAPW]};

  function automatic logic [DW-1:0] swap_rot(input logic [DW-1:0] v);
    return {v[BW-1:0], v[DW-1:BW]};
  endfunction

  always_comb begin
    acc_nxt = acc;
    skip    = 1'b0;
    ior_we  = 1'b0;
    ior_nxt = ior;
    lvl_set = 1'b0;
    lvl_clr = 1'b0;
    strobe  = 1'b0;
    case (op_code)
      OPC_OUT: begin
        if (is_ch1) begin
          ior_we  = 1'b1;
          ior_nxt = acc;
        end else if (is_ch0) begin
          ior_we  = 1'b1;
          ior_nxt = {ior[DW-1:BW], acc[BW-1:0]};
          acc_nxt = swap_rot(acc);
          strobe  = 1'b1;
        end
      end
      OPC_LOAD: begin
        if (is_ch1) begin
          acc_nxt = ior;
        end else if (is_ch0) begin
          acc_nxt = {ior[BW-1:0], acc[HIW-1:0]};
          strobe  = 1'b1;
        end
      end
      OPC_MRG: begin
        if (is_ch1) begin
          acc_nxt = acc | ior;
        end else if (is_ch0) begin
          acc_nxt = swap_rot(merged0);
          strobe  = 1'b1;
        end
      end
      OPC_SETC: lvl_set = is_ch1;
      OPC_CLRF: lvl_clr = is_ch1;
      OPC_CAPT: begin
        if (is_ch1) begin
          ior_we  = 1'b1;
          ior_nxt = {ior[DW-1:CAPW], in_bus[CAPW-1:0]};
        end
      end
      OPC_SKLO: skip = is_ch1 && !lvl_n;
      OPC_SKHI: skip = is_ch1 && lvl_n;
      default: ;
    endcase
  end

  // R8
  sel_code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ior_we && !(is_ch1 && op_code == OPC_OUT)) |-> (ior_nxt[DW-1:CAPW] == ior[DW-1:CAPW]));

  // R11
  bad_chan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ch0 && !is_ch1) |-> (!ior_we && !skip && !strobe && !lvl_set && !lvl_clr && acc_nxt == acc));
endmodule

// File: rtl/chan_ioreg_state.sv
module chan_ioreg_state
  import chan_ioreg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ior_we,
  input  logic [DW-1:0] ior_nxt,
  input  logic          lvl_set,
  input  logic          lvl_clr,
  input  logic          strobe,
  output logic [DW-1:0] ior,
  output logic          lvl_n,
  output logic          ceo_n
);
  logic pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ior   <= '0;
      lvl_n <= 1'b1;
      pulse <= 1'b0;
    end else begin
      if (ior_we) ior <= ior_nxt;
      if (lvl_set)      lvl_n <= 1'b0;
      else if (lvl_clr) lvl_n <= 1'b1;
      pulse <= strobe;
    end
  end

  assign ceo_n = lvl_n & ~pulse;

  // R6
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !ceo_n);

  // R6
  strobe_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceo_n && lvl_n && !strobe && !lvl_set) |=> ceo_n);

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_set && !lvl_clr) |=> (lvl_n == $past(lvl_n)));
endmodule

// File: rtl/chan_ioreg_res_stage.sv
module chan_ioreg_res_stage
  import chan_ioreg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_acc,
  input  logic          in_skip,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_acc,
  output logic          res_skip
);
  logic fire;

  assign in_ready = !res_valid || res_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_acc   <= '0;
      res_skip  <= 1'b0;
    end else if (fire) begin
      res_valid <= 1'b1;
      res_acc   <= in_acc;
      res_skip  <= in_skip;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_acc) && $stable(res_skip)));

  // R9
  res_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready && !in_valid) |=> !res_valid);
endmodule

// File: rtl/chan_ioreg.sv
module chan_ioreg
  import chan_ioreg_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int BW  = BYTE_W,
  parameter int SW  = SEL_W,
  parameter int CW  = CHAN_W,
  parameter int OCW = OPCODE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [OCW-1:0] op_code,
  input  logic [CW-1:0]  op_chan,
  input  logic           op_hold_clr,
  input  logic [DW-1:0]  op_acc,
  input  logic [DW-1:0]  in_bus,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [DW-1:0]  res_acc,
  output logic           res_skip,
  output logic [DW-1:0]  out_bus,
  output logic           ceo_n
);
  logic          fire;
  logic [DW-1:0] ior;
  logic          lvl_n;
  logic [DW-1:0] acc_nxt;
  logic          skip;
  logic          ior_we, lvl_set, lvl_clr, strobe;
  logic [DW-1:0] ior_nxt;

  assign fire    = op_valid && op_ready;
  assign out_bus = ior;

  chan_ioreg_decode #(.DW(DW), .BW(BW), .SW(SW), .CW(CW), .OCW(OCW)) i_decode (
    .clk(clk), .rst_n(rst_n),
    .op_code(op_code), .op_chan(op_chan), .op_hold_clr(op_hold_clr),
    .acc(op_acc), .in_bus(in_bus), .ior(ior), .lvl_n(lvl_n),
    .acc_nxt(acc_nxt), .skip(skip), .ior_we(ior_we), .ior_nxt(ior_nxt),
    .lvl_set(lvl_set), .lvl_clr(lvl_clr), .strobe(strobe)
  );

  chan_ioreg_state #(.DW(DW)) i_state (
    .clk(clk), .rst_n(rst_n),
    .ior_we(ior_we && fire), .ior_nxt(ior_nxt),
    .lvl_set(lvl_set && fire), .lvl_clr(lvl_clr && fire),
    .strobe(strobe && fire),
    .ior(ior), .lvl_n(lvl_n), .ceo_n(ceo_n)
  );

  chan_ioreg_res_stage #(.DW(DW)) i_res (
    .clk(clk), .rst_n(rst_n),
    .in_valid(op_valid), .in_ready(op_ready),
    .in_acc(acc_nxt), .in_skip(skip),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_acc(res_acc), .res_skip(res_skip)
  );

  // R1
  word_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_chan == CW'(1) && op_code == OPC_OUT) |=> (out_bus == $past(op_acc)));

  // R11
  bad_chan_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_chan > CW'(1)) |=> $stable(out_bus));

  // R9
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);
endmodule

// File: tb/test_chan_ioreg.sv
module test_chan_ioreg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [3:0]  op_code = '0;
  logic [4:0]  op_chan = '0;
  logic        op_hold_clr = 1'b0;
  logic [15:0] op_acc = '0;
  logic [15:0] in_bus = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_acc;
  logic        res_skip;
  logic [15:0] out_bus;
  logic        ceo_n;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";

  // reference model state
  logic [15:0] m_ior = '0;
  logic        m_lvl = 1'b1;
  logic        m_pulse = 1'b0;
  logic        m_rv = 1'b0;
  logic [15:0] m_racc = '0;
  logic        m_rskip = 1'b0;

  chan_ioreg i_chan_ioreg (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_chan(op_chan), .op_hold_clr(op_hold_clr),
    .op_acc(op_acc), .in_bus(in_bus), .res_valid(res_valid),
    .res_ready(res_ready), .res_acc(res_acc), .res_skip(res_skip),
    .out_bus(out_bus), .ceo_n(ceo_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] bswap(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ior = '0; m_lvl = 1'b1; m_pulse = 1'b0;
      m_rv = 1'b0; m_racc = '0; m_rskip = 1'b0;
    end else begin
      logic take;
      logic [15:0] a;
      logic sk, pl;
      take = op_valid && (!m_rv || res_ready);
      pl = 1'b0;
      if (take) begin
        a = op_acc; sk = 1'b0;
        if (op_chan == 5'd0) begin
          case (op_code)
            4'd0: begin m_ior[7:0] = op_acc[7:0]; a = bswap(op_acc); pl = 1'b1; end
            4'd1: begin a[15:8] = m_ior[7:0]; pl = 1'b1; end
            4'd2: begin a = bswap(op_acc | {8'h00, m_ior[7:0]}); pl = 1'b1; end
            default: ;
          endcase
        end else if (op_chan == 5'd1) begin
          case (op_code)
            4'd0: m_ior = op_acc;
            4'd1: a = m_ior;
            4'd2: a = op_acc | m_ior;
            4'd3: m_lvl = 1'b0;
            4'd5: m_ior[11:0] = in_bus[11:0];
            4'd6: m_lvl = 1'b1;
            4'd7: sk = !m_lvl;
            4'd8: sk = m_lvl;
            default: ;
          endcase
        end
        m_rv = 1'b1; m_racc = a; m_rskip = sk;
      end else if (res_ready) begin
        m_rv = 1'b0;
      end
      m_pulse = pl;
    end
  end

  task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic compare();
    chk("res_valid (R9)", 16'(res_valid), 16'(m_rv));
    if (m_rv) begin
      chk("res_acc", res_acc, m_racc);
      chk("res_skip (R7)", 16'(res_skip), 16'(m_rskip));
    end
    chk("out_bus (R1)", out_bus, m_ior);
    chk("ceo_n (R6)", 16'(ceo_n), 16'(m_lvl & ~m_pulse));
  endtask

  task automatic step(input string req, input logic v, input logic [3:0] opc,
                      input logic [4:0] ch, input logic [15:0] a,
                      input logic [15:0] ib, input logic rdy);
    @(negedge clk);
    compare();
    cur_req = req;
    op_valid = v; op_code = opc; op_chan = ch; op_acc = a; in_bus = ib;
    res_ready = rdy; op_hold_clr = ~op_hold_clr;
    #1;
    chk("op_ready (R9)", 16'(op_ready), 16'(!m_rv || res_ready));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("reset out_bus R10", out_bus, 16'h0000);
    chk("reset ceo_n R10", 16'(ceo_n), 16'h0001);
    chk("reset res_valid R10", 16'(res_valid), 16'h0000);
    rst_n = 1'b1;

    step("R1", 1, 4'd0, 5'd1, 16'hA5C3, 16'h0, 1);
    step("R2", 1, 4'd1, 5'd1, 16'h0000, 16'h0, 1);
    step("R2", 1, 4'd2, 5'd1, 16'h0F00, 16'h0, 1);
    step("R3", 1, 4'd0, 5'd0, 16'h1234, 16'h0, 1);
    step("R6", 0, 4'd0, 5'd0, 16'h0000, 16'h0, 1);
    step("R4", 1, 4'd1, 5'd0, 16'h00FF, 16'h0, 1);
    step("R5", 1, 4'd2, 5'd0, 16'h1200, 16'h0, 1);
    step("R6", 1, 4'd2, 5'd0, 16'h00FF, 16'h0, 1);
    step("R6", 0, 4'd0, 5'd0, 16'h0000, 16'h0, 1);
    step("R8", 1, 4'd5, 5'd1, 16'h0000, 16'hFFFF, 1);
    step("R8", 1, 4'd1, 5'd1, 16'h0000, 16'h0000, 1);
    step("R7", 1, 4'd3, 5'd1, 16'h0000, 16'h0, 1);
    step("R7", 1, 4'd7, 5'd1, 16'h0000, 16'h0, 1);
    step("R7", 1, 4'd8, 5'd1, 16'h0000, 16'h0, 1);
    step("R7", 1, 4'd6, 5'd1, 16'h0000, 16'h0, 1);
    step("R7", 1, 4'd8, 5'd1, 16'h0000, 16'h0, 1);
    step("R11", 1, 4'd0, 5'd5, 16'h5555, 16'hFFFF, 1);
    step("R11", 1, 4'd5, 5'd0, 16'h7777, 16'h1234, 1);
    step("R11", 1, 4'd4, 5'd1, 16'h3333, 16'h0, 1);
    step("R12", 1, 4'd12, 5'd1, 16'h9999, 16'hFFFF, 1);
    step("R12", 1, 4'd9, 5'd0, 16'h8888, 16'h0, 1);
    step("R9", 1, 4'd0, 5'd1, 16'hBEEF, 16'h0, 0);
    step("R9", 1, 4'd1, 5'd1, 16'h0000, 16'h0, 0);
    step("R9", 1, 4'd1, 5'd1, 16'h0000, 16'h0, 0);
    step("R9", 1, 4'd2, 5'd1, 16'h0001, 16'h0, 1);
    step("R9", 0, 4'd0, 5'd0, 16'h0000, 16'h0, 1);
    step("R9", 0, 4'd0, 5'd0, 16'h0000, 16'h0, 1);

    for (int k = 0; k < 600; k++) begin
      logic [4:0] ch;
      case ($urandom % 6)
        0, 1:    ch = 5'd0;
        2, 3:    ch = 5'd1;
        4:       ch = 5'd31;
        default: ch = 5'(2 + $urandom % 20);
      endcase
      step("R11", ($urandom % 4) != 0, 4'($urandom % 16), ch,
           16'($urandom), 16'($urandom), ($urandom % 3) != 0);
    end
    step("R9", 0, 4'd0, 5'd0, 16'h0, 16'h0, 1);
    step("R9", 0, 4'd0, 5'd0, 16'h0, 16'h0, 1);
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule